// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Control

This block keeps the scheduling state of three CAN transmit message buffers and decides what happens when the CPU asks to withdraw a message. For each buffer it holds an empty flag, an abort-acknowledge flag, an abort-request bit and an interrupt-enable bit. The CPU reaches them through two 8-bit registers: a status register and a control register. The transmit engine reports, per buffer, when an attempt starts and how it ends: success, lost arbitration or a bus error.

An abort is granted at once if the buffer is scheduled but not being sent. If the buffer is on the bus, the abort waits for the attempt to end. A failed attempt then grants the abort, and a successful one wins over it. Whenever a buffer becomes empty, its abort request is dropped in the same edge. The block drives one transmit interrupt, formed from the empty flags gated by their enables.

Top module: `can_txab_top`

## Requirements
- R1: After reset the status register reads 8'h07 (all empty, no acknowledges), the control register reads 8'h00 and `txIrq` is 0.
- R2: A write to the status register (`cpuSel`=0) clears each empty flag in bits 2:0 whose data bit is 1. Data bits of 0 leave the flags unchanged. The acknowledge bits 5:3 and bits 7:6 cannot be written, and bits 7:6 read 0.
- R3: A write to the control register (`cpuSel`=1) loads the interrupt enables from bits 2:0. Each 1 in bits 5:3 sets the abort request of that buffer, but only if the buffer is scheduled (empty 0). A 0 never clears a request, and bits 7:6 read 0.
- R4: A pending abort on a scheduled buffer that is not in transmission is granted on the next edge: the empty flag and the acknowledge flag both become 1.
- R5: While a buffer is in transmission its abort is deferred. If the attempt ends with lost arbitration or an error, the abort is granted on that edge (empty 1, acknowledge 1).
- R6: A successful transmission sets the empty flag and leaves the acknowledge flag at 0, even when an abort request is pending.
- R7: Whenever an empty flag becomes 1 for any reason, that buffer's abort request reads 0 from the same edge.
- R8: Clearing an empty flag also clears that buffer's acknowledge flag.
- R9: `txIrq` is 1 exactly when some buffer has its empty flag and its enable both at 1.
- R10: While `softReset` is 1 the status register is held at 8'h07 and all abort requests read 0. The enables are not affected.
- R11: A failed attempt with no abort pending leaves the buffer scheduled, so the engine may start it again. Engine indications for an empty buffer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softReset | input | 1 | Holds the status register in its reset state |
| cpuWr | input | 1 | CPU write strobe |
| cpuSel | input | 1 | Register select: 0 status, 1 control |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | Read data of the selected register |
| txStart | input | 3 | Engine begins sending buffer i |
| txDone | input | 3 | Attempt on buffer i succeeded |
| txLost | input | 3 | Attempt on buffer i lost arbitration |
| txErr | input | 3 | Attempt on buffer i ended in error |
| txIrq | output | 1 | Combined transmit interrupt |

## Verification
Several kinds of internal fault cannot be seen at once. A wrong in-flight bit reaches the ports only when an abort request meets it. It then shows up as an acknowledge that arrives one edge early, or late, or never. A request that is not dropped when its buffer empties shows in the control read-back on the next cycle. An acknowledge left set after the CPU reschedules the buffer shows in the status read-back on the next cycle. The reference model is compared on every cycle, so each such fault is reported at the first cycle in which it changes a register value or the interrupt.

// File: rtl/can_txab_pkg.sv
package can_txab_pkg;
  parameter int NBUF = 3;
  parameter int REG_W = 8;

  typedef struct packed {
    logic [NBUF-1:0] setDone;   // successful completion
    logic [NBUF-1:0] setAbort;  // abort granted
    logic [NBUF-1:0] clrEmpty;  // CPU reschedules the buffer
    logic [NBUF-1:0] setReq;    // CPU raises an abort request
    logic            wrCtrl;    // load interrupt enables
    logic [NBUF-1:0] ienData;
  } strobes_t;
endpackage

// File: rtl/can_txab_ctrl.sv
module can_txab_ctrl
  import can_txab_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  logic             cpuWr,
  input  logic             cpuSel,
  input  logic [REG_W-1:0] cpuWrData,
  input  logic [NBUF-1:0]  txStart,
  input  logic [NBUF-1:0]  txDone,
  input  logic [NBUF-1:0]  txLost,
  input  logic [NBUF-1:0]  txErr,
  input  logic [NBUF-1:0]  emptyQ,
  input  logic [NBUF-1:0]  reqQ,
  output strobes_t         stb
);
  localparam int REQ_LSB = NBUF;

  logic [NBUF-1:0] flightQ;
  logic [NBUF-1:0] busy, okEnd, failEnd, grant, launch;

  always_comb begin
    busy    = ~emptyQ;
    okEnd   = busy & flightQ & txDone;
    failEnd = busy & flightQ & (txLost | txErr) & ~okEnd;
    grant   = busy & reqQ & (~flightQ | failEnd) & ~okEnd;
    launch  = busy & ~flightQ & txStart & ~grant;
  end

  always_comb begin
    stb          = '0;
    stb.setDone  = okEnd;
    stb.setAbort = grant;
    stb.wrCtrl   = cpuWr & cpuSel;
    stb.ienData  = cpuWrData[NBUF-1:0];
    if (cpuWr && !cpuSel)
      stb.clrEmpty = cpuWrData[NBUF-1:0] & emptyQ;
    if (cpuWr && cpuSel)
      stb.setReq = cpuWrData[REQ_LSB+NBUF-1:REQ_LSB] & busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          flightQ <= '0;
    else if (softReset) flightQ <= '0;
    else                flightQ <= (flightQ & ~(okEnd | grant | failEnd)) | launch;
  end

  // R5: an abort granted while in flight needs a failing end
  a_r5_no_grant_midflight: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.setAbort & flightQ & ~(txLost | txErr)) == '0));

  // R11: only scheduled buffers can be in transmission
  a_r11_flight_scheduled: assert property (@(posedge clk) disable iff (!rstN)
    ((flightQ & emptyQ) == '0));
endmodule

// File: rtl/can_txab_dp.sv
module can_txab_dp
  import can_txab_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             softReset,
  input  strobes_t         stb,
  output logic [NBUF-1:0]  emptyQ,
  output logic [NBUF-1:0]  reqQ,
  output logic [REG_W-1:0] flagRd,
  output logic [REG_W-1:0] ctrlRd,
  output logic             txIrq
);
  localparam int PAD_W = REG_W - 2 * NBUF;

  logic [NBUF-1:0] ackQ, ienQ;
  logic [NBUF-1:0] emptyNext, ackNext, reqNext;

  always_comb begin
    if (softReset) begin
      emptyNext = '1;
      ackNext   = '0;
    end else begin
      emptyNext = (emptyQ | stb.setDone | stb.setAbort) & ~stb.clrEmpty;
      ackNext   = (ackQ | stb.setAbort) & ~stb.clrEmpty;
    end
    reqNext = (reqQ | stb.setReq) & ~emptyNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyQ <= '1;
      ackQ   <= '0;
      reqQ   <= '0;
      ienQ   <= '0;
    end else begin
      emptyQ <= emptyNext;
      ackQ   <= ackNext;
      reqQ   <= reqNext;
      if (stb.wrCtrl) ienQ <= stb.ienData;
    end
  end

  assign flagRd = {{PAD_W{1'b0}}, ackQ, emptyQ};
  assign ctrlRd = {{PAD_W{1'b0}}, reqQ, ienQ};
  assign txIrq  = |(emptyQ & ienQ);

  // R7: a request never coexists with an empty buffer
  a_r7_req_scheduled: assert property (@(posedge clk) disable iff (!rstN)
    ((reqQ & emptyQ) == '0));

  // R8: an acknowledge only survives while the buffer is empty
  a_r8_ack_needs_empty: assert property (@(posedge clk) disable iff (!rstN)
    ((ackQ & ~emptyQ) == '0));

  // R3: a request falls only when its buffer empties
  a_r3_req_set_only: assert property (@(posedge clk) disable iff (!rstN)
    (($past(reqQ) & ~reqQ & ~emptyQ) == '0));

  // R10: soft reset forces the status register
  a_r10_soft_hold: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (emptyQ == '1 && ackQ == '0));

  // R6: success never acknowledges
  a_r6_success_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setDone != '0 && !softReset) |=> ((ackQ & $past(stb.setDone)) == '0));
endmodule

// File: rtl/can_txab_top.sv
module can_txab_top
  import can_txab_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softReset,
  input  logic        cpuWr,
  input  logic        cpuSel,
  input  logic [7:0]  cpuWrData,
  output logic [7:0]  cpuRdData,
  input  logic [2:0]  txStart,
  input  logic [2:0]  txDone,
  input  logic [2:0]  txLost,
  input  logic [2:0]  txErr,
  output logic        txIrq
);
  strobes_t        stb;
  logic [NBUF-1:0] emptyQ, reqQ;
  logic [REG_W-1:0] flagRd, ctrlRd;

  can_txab_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .softReset(softReset),
    .cpuWr(cpuWr), .cpuSel(cpuSel), .cpuWrData(cpuWrData),
    .txStart(txStart), .txDone(txDone), .txLost(txLost), .txErr(txErr),
    .emptyQ(emptyQ), .reqQ(reqQ), .stb(stb)
  );

  can_txab_dp uDp (
    .clk(clk), .rstN(rstN), .softReset(softReset), .stb(stb),
    .emptyQ(emptyQ), .reqQ(reqQ), .flagRd(flagRd), .ctrlRd(ctrlRd),
    .txIrq(txIrq)
  );

  assign cpuRdData = cpuSel ? ctrlRd : flagRd;
endmodule

// File: tb/can_txab_top_test.sv
`timescale 1ns/100ps
module can_txab_top_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic       softReset = 0;
  logic       cpuWr = 0;
  logic       cpuSel = 0;
  logic [7:0] cpuWrData = 0;
  logic [7:0] cpuRdData;
  logic [2:0] txStart = 0, txDone = 0, txLost = 0, txErr = 0;
  logic       txIrq;

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  // behavioural reference state
  bit mEmpty[3], mAck[3], mReq[3], mIen[3], mFly[3];

  always #2 clk = ~clk;

  can_txab_top uut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .cpuWr(cpuWr),
    .cpuSel(cpuSel), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .txStart(txStart), .txDone(txDone), .txLost(txLost), .txErr(txErr),
    .txIrq(txIrq)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mEmpty[i] = 1; mAck[i] = 0; mReq[i] = 0; mIen[i] = 0; mFly[i] = 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        bit wasEmpty, nowEmpty;
        wasEmpty = mEmpty[i];
        if (softReset) begin
          mEmpty[i] = 1; mAck[i] = 0; mFly[i] = 0;
        end else if (!wasEmpty) begin
          if (mFly[i] && txDone[i]) begin
            mEmpty[i] = 1; mFly[i] = 0;              // success wins
          end else if (mFly[i] && (txLost[i] || txErr[i])) begin
            mFly[i] = 0;
            if (mReq[i]) begin mEmpty[i] = 1; mAck[i] = 1; end
          end else if (!mFly[i] && mReq[i]) begin
            mEmpty[i] = 1; mAck[i] = 1;
          end else if (!mFly[i] && txStart[i]) begin
            mFly[i] = 1;
          end
        end else if (cpuWr && !cpuSel && cpuWrData[i]) begin
          mEmpty[i] = 0; mAck[i] = 0;
        end
        nowEmpty = mEmpty[i];
        if (nowEmpty) mReq[i] = 0;
        else if (cpuWr && cpuSel && cpuWrData[3+i] && !wasEmpty) mReq[i] = 1;
        if (cpuWr && cpuSel) mIen[i] = cpuWrData[i];
      end
    end
  end

  function automatic logic [7:0] expFlag();
    return {2'b00, mAck[2], mAck[1], mAck[0], mEmpty[2], mEmpty[1], mEmpty[0]};
  endfunction
  function automatic logic [7:0] expCtrl();
    return {2'b00, mReq[2], mReq[1], mReq[0], mIen[2], mIen[1], mIen[0]};
  endfunction

  task automatic check8(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    cpuSel = 0; #0.5;
    check8("status", cpuRdData, expFlag());
    cpuSel = 1; #0.5;
    check8("control", cpuRdData, expCtrl());
    check8("irq", {7'b0, txIrq},
           {7'b0, (mEmpty[0] & mIen[0]) | (mEmpty[1] & mIen[1]) | (mEmpty[2] & mIen[2])});
  endtask

  task automatic step(input logic w, input logic sel, input logic [7:0] d,
                      input logic [2:0] st, input logic [2:0] dn,
                      input logic [2:0] ls, input logic [2:0] er, input logic sr);
    cpuWr = w; cpuSel = sel; cpuWrData = d;
    txStart = st; txDone = dn; txLost = ls; txErr = er; softReset = sr;
    @(posedge clk);
    @(negedge clk);
    cpuWr = 0; cpuWrData = 0; txStart = 0; txDone = 0; txLost = 0; txErr = 0;
    softReset = 0;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tag = "R1";
    cpuSel = 0; #0.5; check8("reset status", cpuRdData, 8'h07);
    cpuSel = 1; #0.5; check8("reset control", cpuRdData, 8'h00);
    check8("reset irq", {7'b0, txIrq}, 8'h00);
    compareAll();

    tag = "R2";   // clear empty of buffer 0, try writing ack bits and pad bits
    step(1, 0, 8'hF9, 0, 0, 0, 0, 0);
    step(1, 0, 8'h00, 0, 0, 0, 0, 0);

    tag = "R3";   // request on empty buffers ignored, enables loaded
    step(1, 1, 8'hFF, 0, 0, 0, 0, 0);
    step(1, 1, 8'h08, 0, 0, 0, 0, 0);

    tag = "R4";   // buffer 0 aborted before any start
    idle(1);
    cpuSel = 0; #0.5; check8("abort granted", cpuRdData, 8'h0F);
    tag = "R9";
    step(1, 1, 8'h01, 0, 0, 0, 0, 0);
    idle(1);

    tag = "R8";   // rescheduling drops the acknowledge
    step(1, 0, 8'h01, 0, 0, 0, 0, 0);
    cpuSel = 0; #0.5; check8("ack cleared", cpuRdData, 8'h06);

    tag = "R6";   // buffer 1: start, request, success wins
    step(1, 0, 8'h02, 0, 0, 0, 0, 0);
    step(0, 0, 8'h00, 3'b010, 0, 0, 0, 0);
    step(1, 1, 8'h10, 0, 0, 0, 0, 0);
    idle(2);
    tag = "R7";
    step(0, 0, 8'h00, 0, 3'b010, 0, 0, 0);

    tag = "R5";   // buffer 2: start, request, lost arbitration
    step(1, 0, 8'h04, 0, 0, 0, 0, 0);
    step(0, 0, 8'h00, 3'b100, 0, 0, 0, 0);
    step(1, 1, 8'h20, 0, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 8'h00, 0, 0, 3'b100, 0, 0);
    step(1, 0, 8'h02, 0, 0, 0, 0, 0);
    step(0, 0, 8'h00, 3'b010, 0, 0, 0, 0);
    step(1, 1, 8'h10, 0, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 3'b010, 0);

    tag = "R11";  // error without abort, restart, success; events on empty ignored
    step(1, 0, 8'h01, 0, 0, 0, 0, 0);
    step(0, 0, 8'h00, 3'b001, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 3'b001, 0);
    step(0, 0, 8'h00, 3'b111, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 3'b111, 0, 0, 0);

    tag = "R10";  // soft reset with scheduled and requested buffers
    step(1, 0, 8'h07, 0, 0, 0, 0, 0);
    step(1, 1, 8'h3F, 3'b001, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 0, 1);
    step(1, 0, 8'h07, 0, 0, 0, 0, 1);
    idle(1);

    tag = "R9";
    for (int k = 0; k < 600; k++) begin
      logic [7:0] d;
      logic [2:0] r;
      d = 8'($urandom);
      r = 3'($urandom);
      step(($urandom % 3) == 0, r[0], d,
           3'($urandom) & {3{r[1]}}, 3'($urandom) & {3{($urandom % 4) == 0}},
           3'($urandom) & {3{($urandom % 5) == 0}},
           3'($urandom) & {3{($urandom % 6) == 0}},
           ($urandom % 50) == 0);
    end
    finishRun();
  end
endmodule